// File: doc/BRIEF.md
# Charger Fault Condition Monitor

This block turns sampled supply and battery measurements into the protective conditions of a battery charger. On each cycle where a sample strobe is high, it takes the battery voltage, the logic-supply voltage and the thermistor-pin voltage (all unsigned millivolt codes), together with a power-fail indication. From these it derives a power-fail status bit, a battery-present status bit, a control for the input power switch, a charge enable and a one-cycle reset request.

The block also holds the programmed charge-current and charge-voltage settings, which are written through a simple word port. The effective current limit it drives out is the programmed value in normal operation. While the battery is in undervoltage, the output is clamped to a fixed low value and the stored setting is left untouched. The undervoltage condition uses hysteresis, so a battery hovering near the threshold does not make the limit chatter. While the logic supply is low, charging stops, the write port ignores traffic, and the settings are held at their power-on values.

Top module: `chg_fault_mon`

## Requirements
- R1: A sample taken with `pwr_fail_in` high drives `in_switch_on` low and sets `status_word[13]` from the next cycle on. A sample with it low restores the switch and clears the bit.
- R2: After each sample, `status_word[14]` is 1 exactly when thm*100 < vdd*91. All other status bits read 0.
- R3: Battery undervoltage is entered on a sample with battery below 2500 mV and left only on a sample above 2700 mV. Between the two thresholds it keeps its state. It is asserted out of reset.
- R4: While in battery undervoltage, `ilim_ma` reads 128. Otherwise it reads the programmed charge current.
- R5: Battery undervoltage does not alter the programmed settings. `vset_mv` keeps its value, and the programmed current reappears on `ilim_ma` once undervoltage clears.
- R6: A charge-voltage write (`wr_sel`=1) is accepted, and `wr_ack` is high, when the data is at least 1024 mV. A lower value is ignored and not acknowledged. Current writes (`wr_sel`=0) are accepted at any value.
- R7: While the last sample saw the logic supply below 2500 mV, `chg_en` is 0, and writes are neither acknowledged nor stored. Otherwise, `chg_en` is the inverse of the power-fail status.
- R8: On the sample that ends logic-supply undervoltage, `por_req` is high for exactly one cycle, and both settings read their power-on value 0.
- R9: Out of reset, the block shows logic-supply undervoltage: `chg_en` 0, `ilim_ma` 128, status 0, `in_switch_on` 1, `vset_mv` 0, `por_req` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Measurement sample strobe |
| batt_mv | input | 16 | Battery voltage, mV |
| vdd_mv | input | 16 | Logic-supply voltage, mV |
| thm_mv | input | 16 | Thermistor-pin voltage, mV |
| pwr_fail_in | input | 1 | Power-fail indication |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 1 | 0 selects charge current, 1 charge voltage |
| wr_data | input | 16 | Write value (mA or mV) |
| wr_ack | output | 1 | Write accepted this cycle |
| status_word | output | 16 | Bit 14 battery present, bit 13 power fail |
| in_switch_on | output | 1 | Input power switch closed when high |
| ilim_ma | output | 16 | Effective charge-current limit, mA |
| vset_mv | output | 16 | Programmed charge voltage, mV |
| chg_en | output | 1 | Charging allowed |
| por_req | output | 1 | One-cycle reset request on supply recovery |

## Verification
The hardest state to reach from the ports is a programmed current hidden behind an undervoltage clamp. It is visible again only after the battery climbs past the upper threshold, and never inside the hysteresis band. The bench sweeps the battery code upward and downward in fine steps across both thresholds after programming a distinctive current, so each crossing and each in-band hold is compared with an arithmetic model. A second sweep walks the thermistor code one millivolt at a time around the 91 % ratio at two supply levels. A supply dip with a write attempt inside it checks the one-cycle reset pulse and the return of the settings to zero.

// File: rtl/chg_fault_pkg.sv
package chg_fault_pkg;
  localparam int MV_W = 16;
  typedef logic [MV_W-1:0] mv_t;

  localparam mv_t BATT_LO_MV   = 16'd2500;
  localparam mv_t BATT_HI_MV   = 16'd2700;
  localparam mv_t VDD_LO_MV    = 16'd2500;
  localparam mv_t VSET_FLOOR   = 16'd1024;
  localparam mv_t ILIM_CLAMP   = 16'd128;
  localparam int unsigned PRESENT_PCT = 91;

  // next state of a low-side hysteresis flag: set below lo, clear above hi
  function automatic logic hyst_next(input logic cur, input mv_t v,
                                     input mv_t lo, input mv_t hi);
    if (cur) return !(v > hi);
    return (v < lo);
  endfunction

  // battery present when thm/vdd < pct/100, computed without division
  function automatic logic thm_present(input mv_t thm, input mv_t vdd,
                                       input int unsigned pct);
    logic [31:0] lhs;
    logic [31:0] rhs;
    lhs = 32'(thm) * 32'd100;
    rhs = 32'(vdd) * 32'(pct);
    return lhs < rhs;
  endfunction

  function automatic logic vset_ok(input mv_t v, input mv_t floor_mv);
    return v >= floor_mv;
  endfunction
endpackage

// File: rtl/chg_hyst_flag.sv
module chg_hyst_flag
  import chg_fault_pkg::*;
#(
  parameter mv_t  LO      = 16'd2500,
  parameter mv_t  HI      = 16'd2700,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  mv_t  value,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag <= RST_VAL;
    else if (en) flag <= hyst_next(flag, value, LO, HI);
  end
endmodule

// File: rtl/chg_prog_regs.sv
module chg_prog_regs
  import chg_fault_pkg::*;
#(
  parameter mv_t VMIN   = 16'd1024,
  parameter mv_t POR_I  = 16'd0,
  parameter mv_t POR_V  = 16'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_por,
  input  logic wr_en,
  input  logic wr_sel,
  input  mv_t  wr_data,
  output logic wr_ack,
  output mv_t  ichg,
  output mv_t  vset
);
  logic data_ok;

  assign data_ok = wr_sel ? vset_ok(wr_data, VMIN) : 1'b1;
  assign wr_ack  = wr_en && !hold_por && data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ichg <= POR_I;
      vset <= POR_V;
    end else if (hold_por) begin
      ichg <= POR_I;
      vset <= POR_V;
    end else if (wr_ack) begin
      if (wr_sel) vset <= wr_data;
      else        ichg <= wr_data;
    end
  end
endmodule

// File: rtl/chg_fault_mon.sv
module chg_fault_mon
  import chg_fault_pkg::*;
#(
  parameter mv_t         ILIM_UV  = ILIM_CLAMP,
  parameter mv_t         VSET_MIN = VSET_FLOOR,
  parameter mv_t         POR_ICHG = 16'd0,
  parameter mv_t         POR_VSET = 16'd0,
  parameter int unsigned PCT      = PRESENT_PCT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [15:0] batt_mv,
  input  logic [15:0] vdd_mv,
  input  logic [15:0] thm_mv,
  input  logic        pwr_fail_in,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  output logic        wr_ack,
  output logic [15:0] status_word,
  output logic        in_switch_on,
  output logic [15:0] ilim_ma,
  output logic [15:0] vset_mv,
  output logic        chg_en,
  output logic        por_req
);
  localparam int BIT_PF   = 13;
  localparam int BIT_PRES = 14;

  // named internal events for the checker
  logic batt_uv_w;
  logic vdd_uv_w;
  mv_t  ichg_w;
  logic pf_q;
  logic present_q;
  logic por_q;
  logic vdd_recover_w;

  chg_hyst_flag #(.LO(BATT_LO_MV), .HI(BATT_HI_MV), .RST_VAL(1'b1)) u_batt_uv (
    .clk(clk), .rst_n(rst_n), .en(smp_valid), .value(batt_mv), .flag(batt_uv_w)
  );

  // supply flag: no band, cleared at or above the limit
  chg_hyst_flag #(.LO(VDD_LO_MV), .HI(VDD_LO_MV - 16'd1), .RST_VAL(1'b1)) u_vdd_uv (
    .clk(clk), .rst_n(rst_n), .en(smp_valid), .value(vdd_mv), .flag(vdd_uv_w)
  );

  chg_prog_regs #(.VMIN(VSET_MIN), .POR_I(POR_ICHG), .POR_V(POR_VSET)) u_regs (
    .clk(clk), .rst_n(rst_n), .hold_por(vdd_uv_w),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_ack(wr_ack), .ichg(ichg_w), .vset(vset_mv)
  );

  assign vdd_recover_w = smp_valid && vdd_uv_w && !(vdd_mv < VDD_LO_MV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q      <= 1'b0;
      present_q <= 1'b0;
      por_q     <= 1'b0;
    end else begin
      por_q <= vdd_recover_w;
      if (smp_valid) begin
        pf_q      <= pwr_fail_in;
        present_q <= thm_present(thm_mv, vdd_mv, PCT);
      end
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[BIT_PF]   = pf_q;
    status_word[BIT_PRES] = present_q;
  end

  assign in_switch_on = !pf_q;
  assign ilim_ma      = batt_uv_w ? ILIM_UV : ichg_w;
  assign chg_en       = !vdd_uv_w && !pf_q;
  assign por_req      = por_q;
endmodule

// File: rtl/chg_fault_mon_chk.sv
module chg_fault_mon_chk
  import chg_fault_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic [15:0] batt_mv,
  input logic [15:0] vdd_mv,
  input logic [15:0] thm_mv,
  input logic        pwr_fail_in,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] wr_data,
  input logic        wr_ack,
  input logic [15:0] status_word,
  input logic        in_switch_on,
  input logic [15:0] ilim_ma,
  input logic [15:0] vset_mv,
  input logic        chg_en,
  input logic        por_req,
  input logic        batt_uv_w,
  input logic        vdd_uv_w,
  input logic [15:0] ichg_w
);
  p_switch_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && pwr_fail_in |=> !in_switch_on && status_word[13]);

  p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> status_word[14] == ($past(32'(thm_mv)) * 32'd100 < $past(32'(vdd_mv)) * 32'd91));

  p_uv_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && batt_mv < BATT_LO_MV |=> batt_uv_w);

  p_uv_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && batt_mv > BATT_HI_MV |=> !batt_uv_w);

  p_uv_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && batt_mv >= BATT_LO_MV && batt_mv <= BATT_HI_MV |=> $stable(batt_uv_w));

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    batt_uv_w |-> ilim_ma == ILIM_CLAMP);

  p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_uv_w |-> ilim_ma == ichg_w);

  p_vmin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && wr_sel |-> wr_data >= VSET_FLOOR);

  p_vdd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_uv_w |-> !chg_en && !wr_ack);

  p_por_r8: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |-> !vdd_uv_w && ichg_w == 16'd0 && vset_mv == 16'd0);

  p_por_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> !por_req);
endmodule

bind chg_fault_mon chg_fault_mon_chk u_chk (.*);

// File: tb/chg_fault_mon_bench.sv
module chg_fault_mon_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] batt_mv = '0, vdd_mv = '0, thm_mv = '0, wr_data = '0;
  logic        pwr_fail_in = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic        wr_ack, in_switch_on, chg_en, por_req;
  logic [15:0] status_word, ilim_ma, vset_mv;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit m_buv = 1, m_vuv = 1, m_pf = 0, m_pres = 0, m_por = 0;
  int m_i = 0, m_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_fault_mon u_chg_fault_mon (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .batt_mv(batt_mv),
    .vdd_mv(vdd_mv), .thm_mv(thm_mv), .pwr_fail_in(pwr_fail_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_ack(wr_ack),
    .status_word(status_word), .in_switch_on(in_switch_on), .ilim_ma(ilim_ma),
    .vset_mv(vset_mv), .chg_en(chg_en), .por_req(por_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R1 switch", int'(in_switch_on), int'(!m_pf));
    chk("R2 status", int'(status_word), (int'(m_pres) << 14) + (int'(m_pf) << 13));
    chk("R4 ilim", int'(ilim_ma), m_buv ? 128 : m_i);
    chk("R5 vset", int'(vset_mv), m_v);
    chk("R7 chg_en", int'(chg_en), int'(!m_vuv && !m_pf));
    chk("R8 por_req", int'(por_req), int'(m_por));
  endtask

  task automatic do_sample(input int b, input int v, input int t, input bit p);
    bit vlow;
    @(negedge clk);
    batt_mv = 16'(b); vdd_mv = 16'(v); thm_mv = 16'(t); pwr_fail_in = p;
    smp_valid = 1'b1;
    @(posedge clk);
    vlow  = (v < 2500);
    m_por = m_vuv && !vlow;
    if (m_vuv) begin m_i = 0; m_v = 0; end
    m_vuv = vlow;
    if (m_buv) m_buv = !(b > 2700); else m_buv = (b < 2500);
    m_pf   = p;
    m_pres = (v * 91 - t * 100) > 0;
    @(negedge clk);
    smp_valid = 1'b0;
    check_outputs();
  endtask

  task automatic do_write(input bit sel, input int d);
    bit acc;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(d);
    acc = !m_vuv && (!sel || d >= 1024);
    #1 chk("R6 wr_ack", int'(wr_ack), int'(acc));
    @(posedge clk);
    if (m_vuv) begin m_i = 0; m_v = 0; end
    if (acc) begin if (sel) m_v = d; else m_i = d; end
    m_por = 0;
    @(negedge clk);
    wr_en = 1'b0;
    check_outputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state, R3 asserted out of reset
    check_outputs();
    chk("R9 ilim", int'(ilim_ma), 128);
    chk("R9 chg_en", int'(chg_en), 0);
    rst_n = 1'b1;
    // R7: write refused before first good supply sample
    do_write(1'b0, 900);
    do_sample(3000, 3300, 1000, 0);
    do_write(1'b0, 1500);
    // R6 voltage floor
    do_write(1'b1, 1023);
    do_write(1'b1, 1024);
    do_write(1'b1, 8400);
    do_write(1'b0, 50);
    do_write(1'b0, 1500);
    // R3/R4/R5 sweep down then up across both thresholds
    for (int b = 3200; b >= 2000; b -= 10) do_sample(b, 3300, 1000, 0);
    for (int b = 2000; b <= 3200; b += 10) do_sample(b, 3300, 1000, 0);
    do_sample(2700, 3300, 1000, 0);
    do_sample(2499, 3300, 1000, 0);
    do_sample(2700, 3300, 1000, 0);
    do_sample(2701, 3300, 1000, 0);
    chk("R5 restore", int'(ilim_ma), 1500);
    // R2 ratio sweeps
    for (int t = 2990; t <= 3015; t++) do_sample(3000, 3300, t, 0);
    for (int t = 3630; t <= 3650; t++) do_sample(3000, 4000, t, 0);
    // R1 power fail toggling
    do_sample(3000, 3300, 1000, 1);
    do_sample(3000, 3300, 1000, 1);
    do_sample(3000, 3300, 1000, 0);
    do_sample(2400, 3300, 1000, 1);
    do_sample(3000, 3300, 1000, 0);
    // R7/R8 supply dip with write attempt
    do_sample(3000, 2499, 1000, 0);
    do_write(1'b1, 5000);
    do_sample(3000, 2400, 1000, 0);
    do_sample(3000, 2500, 1000, 0);
    chk("R8 pulse", int'(por_req), 1);
    @(negedge clk);
    m_por = 0;
    check_outputs();
    do_write(1'b0, 700);
    do_sample(3000, 3300, 1000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule